// File: doc/BRIEF.md
# Two-Level DMA Interrupt Aggregator

This block gathers interrupt requests from a set of DMA pipes and from a handful of controller-wide event sources, and turns them into one level-sensitive interrupt line per execution environment. Each pipe has a sticky status register, an enable register and a write-one-to-clear register. The controller-wide sources share one status, enable and clear triple of their own. The pipes themselves are outside the block. They appear only as single-cycle event pulses on an input bus.

The first level reduces each pipe to one bit: the OR of its status bits ANDed with its enables. The controller-wide sources are reduced the same way into a summary bit. These bits form a source word, with pipe n in bit n and the controller summary in bit 31. At the second level, each execution environment holds its own 32-bit mask over that word. It sees a masked source view, and its output line is high while any masked source bit is set. Software services an interrupt by reading a status register and writing the value back to the matching clear register. The line falls as soon as the causing bits are gone.

Top module: `irq_agg_top`

## Requirements
- R1: After reset every status bit is 0 and every environment mask is 0. Each pipe enable register reads 0x31: bit 0 is descriptor done, bit 4 is error and bit 5 is transfer end. The controller enable register reads 0x06: bit 1 is bus response error and bit 2 is error. All lines in `envIrq` are low.
- R2: An event pulse on bit b of pipe p (`pipeEvt[6*p+b]`) sets status bit b of that pipe at the next clock edge. The bit stays set until it is cleared. Pipe status bits are: 0 descriptor done, 1 timer, 2 wake, 3 out of descriptors, 4 error, 5 transfer end.
- R3: A write to a pipe clear register clears exactly those status bits of that pipe whose write data bit is 1. Other bits and other pipes are unchanged. The clear register reads as 0.
- R4: Controller-wide status uses bit 1 for bus response error, bit 2 for error, bit 3 for empty and bit 4 for timer. Event `glbEvt[j]` sets bit j, and a write to the controller clear register clears bits written as 1. Bit 0 is reserved: it never sets, and it reads 0 in both status and enable.
- R5: When an event and a clear write hit the same status bit in the same cycle, the event wins and the bit stays set.
- R6: In the raw source word, bit p (for p < NUM_PIPES) is the OR of pipe p's status ANDed with its enable. Bit 31 is the OR of controller status ANDed with controller enable. All other bits are 0.
- R7: Each environment mask register is a full 32-bit read/write register. That environment's masked source view reads as the raw source word ANDed with its mask.
- R8: `envIrq[e]` is high exactly when that environment's masked source view is nonzero. It follows the register state without further delay: it rises in the cycle after the edge that captures the event, and falls in the cycle after the clearing edge.
- R9: Writing an enable register changes only the enable. Status bits keep being recorded while disabled. A pending, disabled bit reaches the source word once it is enabled.
- R10: Register map, using word addresses. 0x000 is controller status, 0x001 is controller clear and 0x002 is controller enable. 0x003 is the raw source word. 0x010+2e is the masked source view of environment e, and 0x011+2e is its mask. 0x100+4p is the status of pipe p, 0x101+4p its clear register and 0x102+4p its enable. Any other address reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 10 | Register word address, used for both read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| pipeEvt | input | 6*NUM_PIPES | Pipe event pulses, six per pipe |
| glbEvt | input | 5 | Controller-wide event pulses; bit 0 is ignored |
| envIrq | output | NUM_ENVS | Level interrupt line per execution environment |

## Verification
A fresh event and a write-one-to-clear on the same status bit can land in the same cycle. A pending bit can also be re-enabled, or its mask written, in the same cycle that another event arrives. The random phase drives sparse event pulses on every cycle, including the cycles that carry clear, enable and mask writes, so these meetings happen throughout the run. Directed cases force the exact collision on a pipe bit and on a controller bit. Each outcome is judged against a bench model in which the event takes priority. Status is read back through the register map, and each output line is compared against the masked model source word in the cycle after every edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int MAX_PIPES   = 31;
  localparam int MAX_ENVS    = 8;
  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 10;
  localparam int PIPE_STS_W  = 6;
  localparam int GLB_STS_W   = 5;
  localparam int SUMMARY_BIT = 31;

  localparam logic [PIPE_STS_W-1:0] PIPE_EN_RST = 6'b110001;
  localparam logic [GLB_STS_W-1:0]  GLB_EN_RST  = 5'b00110;
  localparam logic [GLB_STS_W-1:0]  GLB_VALID   = 5'b11110;

  localparam logic [ADDR_W-1:0] GLB_STS_A   = 10'h000;
  localparam logic [ADDR_W-1:0] GLB_CLR_A   = 10'h001;
  localparam logic [ADDR_W-1:0] GLB_EN_A    = 10'h002;
  localparam logic [ADDR_W-1:0] SRC_RAW_A   = 10'h003;
  localparam logic [ADDR_W-1:0] ENV_BASE_A  = 10'h010;
  localparam logic [ADDR_W-1:0] PIPE_BASE_A = 10'h100;

  typedef enum logic [2:0] {
    RD_NONE, RD_GSTS, RD_GEN, RD_RAW, RD_ENVSRC, RD_MASK, RD_PSTS, RD_PEN
  } rdSel_e;

  typedef struct packed {
    logic [MAX_PIPES-1:0] pipeClr;
    logic [MAX_PIPES-1:0] pipeEnWr;
    logic                 glbClr;
    logic                 glbEnWr;
    logic [MAX_ENVS-1:0]  maskWr;
    rdSel_e               rdSel;
    logic [4:0]           rdIdx;
  } strobes_t;
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int NUM_PIPES = 31,
  parameter int NUM_ENVS  = 2
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobes_t          stb
);
  logic [4:0] pipeIdx;
  logic [2:0] envIdx;
  logic       inPipe;
  logic       inEnv;

  assign pipeIdx = addr[6:2];
  assign envIdx  = addr[3:1];
  assign inPipe  = (addr[9:7] == 3'b010) && (int'(pipeIdx) < NUM_PIPES);
  assign inEnv   = (addr[9:4] == ENV_BASE_A[9:4]) && (int'(envIdx) < NUM_ENVS);

  always_comb begin
    stb       = '0;
    stb.rdSel = RD_NONE;
    if (inPipe) begin
      stb.rdIdx = pipeIdx;
      case (addr[1:0])
        2'd0: stb.rdSel = RD_PSTS;
        2'd1: stb.pipeClr[pipeIdx] = wrEn;
        2'd2: begin
          stb.rdSel = RD_PEN;
          stb.pipeEnWr[pipeIdx] = wrEn;
        end
        default: stb.rdSel = RD_NONE;
      endcase
    end else if (inEnv) begin
      stb.rdIdx = {2'b00, envIdx};
      if (addr[0]) begin
        stb.rdSel = RD_MASK;
        stb.maskWr[envIdx] = wrEn;
      end else begin
        stb.rdSel = RD_ENVSRC;
      end
    end else begin
      case (addr)
        GLB_STS_A: stb.rdSel = RD_GSTS;
        GLB_CLR_A: stb.glbClr = wrEn;
        GLB_EN_A: begin
          stb.rdSel = RD_GEN;
          stb.glbEnWr = wrEn;
        end
        SRC_RAW_A: stb.rdSel = RD_RAW;
        default: stb.rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int NUM_PIPES = 31,
  parameter int NUM_ENVS  = 2
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  strobes_t                         stb,
  input  logic [DATA_W-1:0]                wrData,
  input  logic [NUM_PIPES*PIPE_STS_W-1:0]  pipeEvt,
  input  logic [GLB_STS_W-1:0]             glbEvt,
  output logic [DATA_W-1:0]                rdData,
  output logic [NUM_PIPES*PIPE_STS_W-1:0]  pipeStsFlat,
  output logic [GLB_STS_W-1:0]             glbSts,
  output logic [DATA_W-1:0]                srcRaw,
  output logic [NUM_ENVS*DATA_W-1:0]       maskFlat,
  output logic [NUM_ENVS-1:0]              envIrq
);
  logic [NUM_PIPES*PIPE_STS_W-1:0] pipeEnFlat;
  logic [GLB_STS_W-1:0]            glbEn;

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    logic [PIPE_STS_W-1:0] sts;
    logic [PIPE_STS_W-1:0] en;
    logic [PIPE_STS_W-1:0] clrBits;

    assign clrBits = stb.pipeClr[p] ? wrData[PIPE_STS_W-1:0] : '0;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        sts <= '0;
        en  <= PIPE_EN_RST;
      end else begin
        sts <= (sts & ~clrBits) | pipeEvt[p*PIPE_STS_W +: PIPE_STS_W];
        if (stb.pipeEnWr[p]) en <= wrData[PIPE_STS_W-1:0];
      end
    end

    assign pipeStsFlat[p*PIPE_STS_W +: PIPE_STS_W] = sts;
    assign pipeEnFlat[p*PIPE_STS_W +: PIPE_STS_W]  = en;
    assign srcRaw[p] = |(sts & en);
  end

  if (NUM_PIPES < SUMMARY_BIT) begin : g_pad
    assign srcRaw[SUMMARY_BIT-1:NUM_PIPES] = '0;
  end

  logic [GLB_STS_W-1:0] glbClrBits;
  assign glbClrBits = stb.glbClr ? wrData[GLB_STS_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      glbSts <= '0;
      glbEn  <= GLB_EN_RST;
    end else begin
      glbSts <= (glbSts & ~glbClrBits) | (glbEvt & GLB_VALID);
      if (stb.glbEnWr) glbEn <= wrData[GLB_STS_W-1:0] & GLB_VALID;
    end
  end

  assign srcRaw[SUMMARY_BIT] = |(glbSts & glbEn);

  for (genvar e = 0; e < NUM_ENVS; e++) begin : g_env
    logic [DATA_W-1:0] mask;
    always_ff @(posedge clk) begin
      if (!rstN)              mask <= '0;
      else if (stb.maskWr[e]) mask <= wrData;
    end
    assign maskFlat[e*DATA_W +: DATA_W] = mask;
    assign envIrq[e] = |(srcRaw & mask);
  end

  always_comb begin
    case (stb.rdSel)
      RD_GSTS:   rdData = {{(DATA_W-GLB_STS_W){1'b0}}, glbSts};
      RD_GEN:    rdData = {{(DATA_W-GLB_STS_W){1'b0}}, glbEn};
      RD_RAW:    rdData = srcRaw;
      RD_ENVSRC: rdData = srcRaw & maskFlat[int'(stb.rdIdx)*DATA_W +: DATA_W];
      RD_MASK:   rdData = maskFlat[int'(stb.rdIdx)*DATA_W +: DATA_W];
      RD_PSTS:   rdData = {{(DATA_W-PIPE_STS_W){1'b0}},
                           pipeStsFlat[int'(stb.rdIdx)*PIPE_STS_W +: PIPE_STS_W]};
      RD_PEN:    rdData = {{(DATA_W-PIPE_STS_W){1'b0}},
                           pipeEnFlat[int'(stb.rdIdx)*PIPE_STS_W +: PIPE_STS_W]};
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int NUM_PIPES = 31,
  parameter int NUM_ENVS  = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            wrEn,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wrData,
  output logic [DATA_W-1:0]               rdData,
  input  logic [NUM_PIPES*PIPE_STS_W-1:0] pipeEvt,
  input  logic [GLB_STS_W-1:0]            glbEvt,
  output logic [NUM_ENVS-1:0]             envIrq
);
  strobes_t                        stb;
  logic [NUM_PIPES*PIPE_STS_W-1:0] pipeStsFlat;
  logic [GLB_STS_W-1:0]            glbSts;
  logic [DATA_W-1:0]               srcRaw;
  logic [NUM_ENVS*DATA_W-1:0]      maskFlat;

  irq_agg_ctrl #(.NUM_PIPES(NUM_PIPES), .NUM_ENVS(NUM_ENVS)) ctrlI (
    .wrEn (wrEn),
    .addr (addr),
    .stb  (stb)
  );

  irq_agg_datapath #(.NUM_PIPES(NUM_PIPES), .NUM_ENVS(NUM_ENVS)) dpI (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wrData      (wrData),
    .pipeEvt     (pipeEvt),
    .glbEvt      (glbEvt),
    .rdData      (rdData),
    .pipeStsFlat (pipeStsFlat),
    .glbSts      (glbSts),
    .srcRaw      (srcRaw),
    .maskFlat    (maskFlat),
    .envIrq      (envIrq)
  );
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int NUM_PIPES = 31,
  parameter int NUM_ENVS  = 2
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            wrEn,
  input logic [ADDR_W-1:0]               addr,
  input logic [DATA_W-1:0]               wrData,
  input logic [NUM_PIPES*PIPE_STS_W-1:0] pipeEvt,
  input logic [GLB_STS_W-1:0]            glbEvt,
  input logic [NUM_PIPES*PIPE_STS_W-1:0] pipeStsFlat,
  input logic [GLB_STS_W-1:0]            glbSts,
  input logic [DATA_W-1:0]               srcRaw,
  input logic [NUM_ENVS*DATA_W-1:0]      maskFlat,
  input logic [NUM_ENVS-1:0]             envIrq
);
  logic unusedBits;
  assign unusedBits = ^wrData[DATA_W-1:PIPE_STS_W] ^ glbEvt[0];

  for (genvar i = 0; i < NUM_PIPES*PIPE_STS_W; i++) begin : g_bit
    localparam int P = i / PIPE_STS_W;
    localparam int B = i % PIPE_STS_W;
    localparam logic [ADDR_W-1:0] CLR_A = PIPE_BASE_A + ADDR_W'(4*P + 1);

    p_pipe_set_r2: assert property (@(posedge clk) disable iff (!rstN)
      pipeEvt[i] |=> pipeStsFlat[i]);

    p_pipe_clr_r3: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == CLR_A && wrData[B] && !pipeEvt[i]) |=> !pipeStsFlat[i]);

    p_evt_over_clr_r5: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == CLR_A && wrData[B] && pipeEvt[i]) |=> pipeStsFlat[i]);
  end

  for (genvar j = 1; j < GLB_STS_W; j++) begin : g_glb
    p_glb_set_r4: assert property (@(posedge clk) disable iff (!rstN)
      glbEvt[j] |=> glbSts[j]);

    p_glb_clr_r4: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == GLB_CLR_A && wrData[j] && !glbEvt[j]) |=> !glbSts[j]);
  end

  p_glb_rsvd_r4: assert property (@(posedge clk) disable iff (!rstN)
    !glbSts[0]);

  for (genvar e = 0; e < NUM_ENVS; e++) begin : g_env
    p_masked_off_r8: assert property (@(posedge clk) disable iff (!rstN)
      (maskFlat[e*DATA_W +: DATA_W] == '0) |-> !envIrq[e]);

    p_irq_has_src_r6: assert property (@(posedge clk) disable iff (!rstN)
      envIrq[e] |-> (srcRaw != '0));
  end
endmodule

bind irq_agg_top irq_agg_chk #(.NUM_PIPES(NUM_PIPES), .NUM_ENVS(NUM_ENVS)) chkI (
  .clk         (clk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .addr        (addr),
  .wrData      (wrData),
  .pipeEvt     (pipeEvt),
  .glbEvt      (glbEvt),
  .pipeStsFlat (pipeStsFlat),
  .glbSts      (glbSts),
  .srcRaw      (srcRaw),
  .maskFlat    (maskFlat),
  .envIrq      (envIrq)
);

// File: tb/irq_agg_top_tb_top.sv
module irq_agg_top_tb_top;
  localparam int NP = 31;
  localparam int NE = 2;
  localparam int EW = NP*6;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            wrEn = 1'b0;
  logic [9:0]      addr = '0;
  logic [31:0]     wrData = '0;
  logic [31:0]     rdData;
  logic [EW-1:0]   pipeEvt = '0;
  logic [4:0]      glbEvt = '0;
  logic [NE-1:0]   envIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [5:0]  mPSts [NP];
  logic [5:0]  mPEn  [NP];
  logic [4:0]  mGSts;
  logic [4:0]  mGEn;
  logic [31:0] mMask [NE];

  irq_agg_top #(.NUM_PIPES(NP), .NUM_ENVS(NE)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pipeEvt(pipeEvt), .glbEvt(glbEvt), .envIrq(envIrq)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] mRaw();
    logic [31:0] r = '0;
    for (int p = 0; p < NP; p++) r[p] = |(mPSts[p] & mPEn[p]);
    r[31] = |(mGSts & mGEn);
    return r;
  endfunction

  function automatic logic [31:0] mRead(logic [9:0] a);
    if (a[9:7] == 3'b010) begin
      int p = int'(a[6:2]);
      if (p >= NP) return '0;
      if (a[1:0] == 2'd0) return {26'd0, mPSts[p]};
      if (a[1:0] == 2'd2) return {26'd0, mPEn[p]};
      return '0;
    end
    if (a[9:4] == 6'h01) begin
      int e = int'(a[3:1]);
      if (e >= NE) return '0;
      return a[0] ? mMask[e] : (mRaw() & mMask[e]);
    end
    case (a)
      10'h000: return {27'd0, mGSts};
      10'h002: return {27'd0, mGEn};
      10'h003: return mRaw();
      default: return '0;
    endcase
  endfunction

  function automatic string reqOf(logic [9:0] a);
    if (a[9:7] == 3'b010 && int'(a[6:2]) < NP)
      return (a[1:0] == 2'd2) ? "R9" : "R2";
    if (a[9:4] == 6'h01 && int'(a[3:1]) < NE) return "R7";
    if (a == 10'h000) return "R4";
    if (a == 10'h002) return "R9";
    if (a == 10'h003) return "R6";
    return "R10";
  endfunction

  task automatic mReset();
    for (int p = 0; p < NP; p++) begin mPSts[p] = '0; mPEn[p] = 6'h31; end
    mGSts = '0; mGEn = 5'h06;
    for (int e = 0; e < NE; e++) mMask[e] = '0;
  endtask

  task automatic mUpdate(bit wr, logic [9:0] a, logic [31:0] d,
                         logic [EW-1:0] pe, logic [4:0] ge);
    for (int p = 0; p < NP; p++) begin
      logic [9:0] base = 10'h100 + 10'(4*p);
      logic [5:0] clr = (wr && a == base + 10'd1) ? d[5:0] : 6'd0;
      mPSts[p] = (mPSts[p] & ~clr) | pe[p*6 +: 6];
      if (wr && a == base + 10'd2) mPEn[p] = d[5:0];
    end
    begin
      logic [4:0] gclr = (wr && a == 10'h001) ? d[4:0] : 5'd0;
      mGSts = (mGSts & ~gclr) | (ge & 5'b11110);
    end
    if (wr && a == 10'h002) mGEn = d[4:0] & 5'b11110;
    for (int e = 0; e < NE; e++)
      if (wr && a == 10'h011 + 10'(2*e)) mMask[e] = d;
  endtask

  task automatic check(logic [31:0] got, logic [31:0] exp, string req);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h (time %0t)", req, got, exp, $time);
    end
  endtask

  // Starts and ends at a falling edge.
  task automatic step(bit wr, logic [9:0] a, logic [31:0] d,
                      logic [EW-1:0] pe, logic [4:0] ge);
    wrEn = wr; addr = a; wrData = d; pipeEvt = pe; glbEvt = ge;
    #1;
    if (!wr) check(rdData, mRead(a), reqOf(a));
    @(posedge clk);
    mUpdate(wr, a, d, pe, ge);
    @(negedge clk);
    for (int e = 0; e < NE; e++)
      check({31'd0, envIrq[e]}, {31'd0, |(mRaw() & mMask[e])}, "R8");
  endtask

  task automatic rdChk(logic [9:0] a, logic [31:0] exp, string req);
    wrEn = 1'b0; addr = a; pipeEvt = '0; glbEvt = '0;
    #1;
    check(rdData, exp, req);
  endtask

  function automatic logic [9:0] randAddr();
    int k = int'($urandom % 8);
    case (k)
      0, 1: return 10'h100 + 10'(4*($urandom % NP)) + 10'($urandom % 3);
      2:    return 10'h100 + 10'(4*($urandom % NP)) + 10'd1;
      3:    return 10'($urandom % 4);
      4:    return 10'h010 + 10'($urandom % (2*NE));
      5:    return 10'h011 + 10'(2*($urandom % NE));
      6:    return 10'h001;
      default: return 10'($urandom % 1024);
    endcase
  endfunction

  initial begin
    #(1_500_000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    rdChk(10'h002, 32'h06, "R1");
    rdChk(10'h102, 32'h31, "R1");
    rdChk(10'h000, 32'h00, "R1");
    rdChk(10'h011, 32'h00, "R1");
    check({30'd0, envIrq}, 32'd0, "R1");

    // open all masks
    step(1'b1, 10'h011, 32'hFFFF_FFFF, '0, '0);
    step(1'b1, 10'h013, 32'h8000_0001, '0, '0);

    // R2 event on pipe 3 bit 4 sets and stays
    begin
      logic [EW-1:0] pe = '0;
      pe[3*6+4] = 1'b1;
      step(1'b0, 10'h10C, '0, pe, '0);
      step(1'b0, 10'h10C, '0, '0, '0);
      rdChk(10'h10C, 32'h10, "R2");
      rdChk(10'h003, 32'h0000_0008, "R6");
    end

    // R3 clear write of the read value
    step(1'b1, 10'h10D, 32'h10, '0, '0);
    rdChk(10'h10C, 32'h0, "R3");
    check({30'd0, envIrq}, 32'd0, "R8");

    // R5 event and clear on the same bit in one cycle
    begin
      logic [EW-1:0] pe = '0;
      pe[3*6+0] = 1'b1;
      step(1'b0, 10'h10C, '0, pe, '0);
      step(1'b1, 10'h10D, 32'h01, pe, '0);
      rdChk(10'h10C, 32'h01, "R5");
      step(1'b1, 10'h10D, 32'h01, '0, '0);
      rdChk(10'h10C, 32'h00, "R3");
    end

    // R4 controller sources, reserved bit 0 ignored, event beats clear
    step(1'b0, 10'h000, '0, '0, 5'b00101);
    rdChk(10'h000, 32'h04, "R4");
    check({31'd0, envIrq[1]}, 32'd1, "R8");
    step(1'b1, 10'h001, 32'h04, '0, 5'b00100);
    rdChk(10'h000, 32'h04, "R5");
    step(1'b1, 10'h001, 32'h1F, '0, '0);
    rdChk(10'h000, 32'h00, "R4");
    step(1'b1, 10'h002, 32'h1F, '0, '0);
    rdChk(10'h002, 32'h1E, "R4");

    // R9 disabled pending bit kept, then enabled
    begin
      logic [EW-1:0] pe = '0;
      step(1'b1, 10'h116, 32'h00, '0, '0);
      pe[5*6+1] = 1'b1;
      step(1'b0, 10'h114, '0, pe, '0);
      rdChk(10'h114, 32'h02, "R9");
      rdChk(10'h003, 32'h0, "R9");
      check({30'd0, envIrq}, 32'd0, "R9");
      step(1'b1, 10'h116, 32'h02, '0, '0);
      rdChk(10'h003, 32'h0000_0020, "R9");
      check({31'd0, envIrq[0]}, 32'd1, "R9");
      step(1'b1, 10'h115, 32'h3F, '0, '0);
    end

    // R10 unmapped and reserved addresses
    rdChk(10'h3FF, 32'h0, "R10");
    rdChk(10'h17C, 32'h0, "R10");
    rdChk(10'h015, 32'h0, "R10");

    // constrained random mix
    for (int it = 0; it < 4000; it++) begin
      logic [EW-1:0] pe = '0;
      logic [4:0]    ge = '0;
      bit            wr = ($urandom % 2) == 0;
      logic [9:0]    a  = randAddr();
      logic [31:0]   d  = $urandom;
      for (int b = 0; b < EW; b++) pe[b] = ($urandom % 24) == 0;
      for (int b = 0; b < 5; b++)  ge[b] = ($urandom % 12) == 0;
      if (($urandom % 3) == 0) d = d | 32'h3F;
      step(wr, a, d, pe, ge);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule